// File: doc/BRIEF.md
# Priority Run-Queue Thread Scheduler

This block decides, on every clock cycle, which hardware thread context may issue its next instruction. Live threads wait in one of two FIFO run queues, a high-priority queue and a low-priority queue. Each thread carries a readiness tag, which is the earliest value of the free-running 16-bit cycle count at which it may issue again. The block looks only at the head entry of each queue. It serves the high queue when that head is due and otherwise the low queue when that head is due. If neither head is due, the cycle idles.

The instruction pipeline reports back on an issued thread with a feedback strobe. The report carries the thread id, a 2-bit minimum-delay code, a terminate flag and a fork request. A surviving thread goes back to the tail of its own queue with a new tag, so threads of equal priority take turns one instruction at a time. A terminating thread returns its slot to the free pool. An interrupt request and a fork both ask for a new task. Each request takes the lowest free slot. When no slot is free, one request is held back until a slot frees up, and any further request is refused with a fault pulse.

Top module: `thread_issue_sched`

## Requirements
- R1: Synchronous reset leaves slot 0 as the only live thread, queued at low priority and due from the first cycle after reset. Slots 1 to 7 are free and no spawn is held back.
- R2: When the head of the high queue is due, it is issued with issue_hi_o=1, whatever the low queue holds.
- R3: A thread whose feedback has fb_term_i=0 is appended to the tail of its own priority queue. Due threads of equal priority therefore issue in strict rotation.
- R4: Feedback with delay code d (0 to 3) sets the thread's tag to cycle_i+d+1, so the thread issues again no earlier than d+1 cycles later.
- R5: A tag counts as due when (cycle_i - tag) mod 2^16 is below 2^15. Delays therefore behave the same across the wrap of the cycle count.
- R6: Only queue heads are examined. When neither head is due, issue_valid_o is 0, even if a due entry waits behind a head that is not due.
- R7: Feedback with fb_term_i=1 drops the thread and frees its slot from the next cycle on. A later spawn reuses the lowest-numbered free slot.
- R8: A granted spawn raises spawn_valid_o with the lowest free slot in spawn_tid_o. The child is appended to the high queue (interrupt, or fork with fb_fork_hi_i=1) or to the low queue, and is due from the next cycle.
- R9: At most one spawn is granted per cycle. The order is the held-back request first, then the interrupt, then the fork.
- R10: A request that is not granted becomes the held-back request, with spawn_defer_o=1, when no held-back request remains after that cycle. Any other request that is not granted is discarded, with spawn_fault_o=1.
- R11: When a slot frees while a request is held back, the held-back request takes that slot before any fork made in the same cycle. That fork is then held back in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_i | input | 16 | Free-running wrapping cycle count |
| fb_valid_i | input | 1 | Feedback strobe for an issued thread |
| fb_tid_i | input | 3 | Thread id the feedback refers to |
| fb_delay_i | input | 2 | Minimum-delay code d; the thread waits d+1 cycles |
| fb_term_i | input | 1 | The thread ends and its slot is freed |
| fb_fork_i | input | 1 | The thread asks to spawn a child |
| fb_fork_hi_i | input | 1 | The child goes to the high queue when 1 |
| irq_i | input | 1 | Interrupt: spawn a high-priority task |
| issue_valid_o | output | 1 | A thread is issued this cycle |
| issue_tid_o | output | 3 | Issued thread id |
| issue_hi_o | output | 1 | The issued thread came from the high queue |
| spawn_valid_o | output | 1 | A spawn is granted this cycle |
| spawn_tid_o | output | 3 | Slot given to the spawned task |
| spawn_hi_o | output | 1 | The spawned task is queued at high priority |
| spawn_defer_o | output | 1 | A new spawn request was held back |
| spawn_fault_o | output | 1 | A spawn request was discarded |

## Verification
Some properties are checked by the assertions on every cycle. An issued thread never owns a free slot. Queued entries plus free slots never exceed the slot count. A run queue never overflows or underflows. A granted slot leaves the free pool, and a held-back request is latched. Some behaviour can only be shown by the bench scenarios, which follow a cycle-accurate reference model. These are the exact rotation order, the cycle on which a delayed thread returns, including across the counter wrap, head-of-line idling, and the arbitration between the held-back request, the interrupt and the fork when the pool is full or a slot has just freed.

// File: rtl/sched_pkg.sv
`timescale 1ns/1ps
package sched_pkg;

    localparam int unsigned SLOTS = 8;
    localparam int unsigned TID_W = $clog2(SLOTS);
    localparam int unsigned CYC_W = 16;
    localparam int unsigned DLY_W = 2;
    localparam int unsigned NREQ  = 3;  // held-back, interrupt, fork

    typedef logic [TID_W-1:0] tid_t;
    typedef logic [CYC_W-1:0] cyc_t;
    typedef logic [DLY_W-1:0] dly_t;

    typedef enum logic {
        PRIO_LO = 1'b0,
        PRIO_HI = 1'b1
    } prio_e;

    typedef struct packed {
        logic  req;
        prio_e prio;
    } spawn_req_t;

    typedef struct packed {
        logic  valid;
        tid_t  tid;
        prio_e prio;
    } pick_t;

    // Due when now is at or past tag within half the counter range.
    function automatic logic tag_due(input cyc_t now, input cyc_t tag);
        cyc_t diff;
        diff = now - tag;
        return ~diff[CYC_W-1];
    endfunction

    // Earliest issue cycle after an instruction with delay code d.
    function automatic cyc_t delay_tag(input cyc_t now, input dly_t code);
        return now + cyc_t'(code) + cyc_t'(1);
    endfunction

    function automatic tid_t lowest_set(input logic [SLOTS-1:0] mask);
        tid_t r;
        r = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (mask[i]) r = tid_t'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/sched_runq.sv
`timescale 1ns/1ps
// Circular FIFO of thread ids with two ordered push ports and one pop.
// DEPTH must be a power of two so the pointers wrap on their own.
module sched_runq #(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned W       = 3,
    parameter bit          PRELOAD = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   push_a_i,
    input  logic [W-1:0]           push_a_data_i,
    input  logic                   push_b_i,
    input  logic [W-1:0]           push_b_data_i,
    input  logic                   pop_i,
    output logic [W-1:0]           head_o,
    output logic [$clog2(DEPTH):0] count_o,
    output logic                   empty_o
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = PW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    n_push;
    logic [PW-1:0] b_addr;

    assign n_push  = {1'b0, push_a_i} + {1'b0, push_b_i};
    assign b_addr  = push_a_i ? wr_q + PW'(1) : wr_q;
    assign head_o  = mem[rd_q];
    assign count_o = cnt_q;
    assign empty_o = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= PRELOAD ? PW'(1) : '0;
            cnt_q <= PRELOAD ? CW'(1) : '0;
            if (PRELOAD) mem[0] <= '0;
        end else begin
            if (push_a_i) mem[wr_q]   <= push_a_data_i;
            if (push_b_i) mem[b_addr] <= push_b_data_i;
            wr_q  <= wr_q + PW'(n_push);
            rd_q  <= rd_q + PW'(pop_i);
            cnt_q <= cnt_q + CW'(n_push) - CW'(pop_i);
        end
    end

    AST_RUNQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt_q) + int'(n_push) - int'(pop_i)) <= int'(DEPTH)); // R3
    AST_RUNQ_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> (cnt_q != '0)); // R6

endmodule

// File: rtl/sched_tag_table.sv
`timescale 1ns/1ps
// Per-slot readiness tag and priority, with a requeue write port,
// a spawn write port and three read ports.
module sched_tag_table
    import sched_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cyc_t  cycle_i,
    input  logic  rq_we_i,
    input  tid_t  rq_tid_i,
    input  cyc_t  rq_tag_i,
    input  logic  sp_we_i,
    input  tid_t  sp_tid_i,
    input  cyc_t  sp_tag_i,
    input  prio_e sp_prio_i,
    input  tid_t  rd_a_tid_i,
    output cyc_t  rd_a_tag_o,
    input  tid_t  rd_b_tid_i,
    output cyc_t  rd_b_tag_o,
    input  tid_t  rd_c_tid_i,
    output prio_e rd_c_prio_o
);
    cyc_t  tag_all  [SLOTS];
    prio_e prio_all [SLOTS];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        cyc_t  tag_r;
        prio_e prio_r;
        logic  sp_hit, rq_hit;

        assign sp_hit = sp_we_i && (sp_tid_i == tid_t'(s));
        assign rq_hit = rq_we_i && (rq_tid_i == tid_t'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_r  <= (s == 0) ? cycle_i : '0;
                prio_r <= PRIO_LO;
            end else if (sp_hit) begin
                tag_r  <= sp_tag_i;
                prio_r <= sp_prio_i;
            end else if (rq_hit) begin
                tag_r  <= rq_tag_i;
            end
        end

        assign tag_all[s]  = tag_r;
        assign prio_all[s] = prio_r;
    end

    assign rd_a_tag_o  = tag_all[rd_a_tid_i];
    assign rd_b_tag_o  = tag_all[rd_b_tid_i];
    assign rd_c_prio_o = prio_all[rd_c_tid_i];

    AST_TAG_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (rq_we_i && sp_we_i) |-> (rq_tid_i != sp_tid_i)); // R8

endmodule

// File: rtl/sched_slot_pool.sv
`timescale 1ns/1ps
// Free-slot mask plus one held-back spawn request and the spawn arbiter.
module sched_slot_pool
    import sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             irq_i,
    input  logic             fork_i,
    input  prio_e            fork_prio_i,
    input  logic             release_i,
    input  tid_t             release_tid_i,
    output logic             grant_valid_o,
    output tid_t             grant_tid_o,
    output prio_e            grant_prio_o,
    output logic             defer_o,
    output logic             fault_o,
    output logic [SLOTS-1:0] free_mask_o
);
    logic [SLOTS-1:0] free_q, free_n;
    spawn_req_t       pend_q, pend_n;
    spawn_req_t       req [NREQ];
    logic             first_found, have_rem;
    int               gidx;

    // Requests in arbitration order: held-back, interrupt, fork.
    always_comb begin
        req[0] = pend_q;
        req[1] = '{req: irq_i,  prio: PRIO_HI};
        req[2] = '{req: fork_i, prio: fork_prio_i};

        first_found = 1'b0;
        gidx        = 0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i].req && !first_found) begin
                first_found = 1'b1;
                gidx        = i;
            end
        end
        grant_valid_o = first_found && (free_q != '0);
        grant_prio_o  = req[gidx].prio;
        grant_tid_o   = lowest_set(free_q);

        pend_n   = '0;
        have_rem = 1'b0;
        defer_o  = 1'b0;
        fault_o  = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i].req && !(grant_valid_o && (gidx == i))) begin
                if (!have_rem) begin
                    have_rem = 1'b1;
                    pend_n   = req[i];
                    defer_o  = (i != 0);
                end else begin
                    fault_o  = 1'b1;
                end
            end
        end
    end

    always_comb begin
        free_n = free_q;
        if (grant_valid_o) free_n[grant_tid_o]   = 1'b0;
        if (release_i)     free_n[release_tid_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q <= {{(SLOTS-1){1'b1}}, 1'b0};
            pend_q <= '0;
        end else begin
            free_q <= free_n;
            pend_q <= pend_n;
        end
    end

    assign free_mask_o = free_q;

    AST_GRANT_TAKES_SLOT: assert property (@(posedge clk) disable iff (rst)
        grant_valid_o |=> !free_q[$past(grant_tid_o)]); // R8
    AST_DEFER_HELD: assert property (@(posedge clk) disable iff (rst)
        defer_o |=> pend_q.req); // R10
    AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (rst)
        release_i |=> free_q[$past(release_tid_i)]); // R7

endmodule

// File: rtl/thread_issue_sched.sv
`timescale 1ns/1ps
module thread_issue_sched
    import sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CYC_W-1:0] cycle_i,
    input  logic             fb_valid_i,
    input  logic [TID_W-1:0] fb_tid_i,
    input  logic [DLY_W-1:0] fb_delay_i,
    input  logic             fb_term_i,
    input  logic             fb_fork_i,
    input  logic             fb_fork_hi_i,
    input  logic             irq_i,
    output logic             issue_valid_o,
    output logic [TID_W-1:0] issue_tid_o,
    output logic             issue_hi_o,
    output logic             spawn_valid_o,
    output logic [TID_W-1:0] spawn_tid_o,
    output logic             spawn_hi_o,
    output logic             spawn_defer_o,
    output logic             spawn_fault_o
);
    localparam int unsigned NPRIO = 2;

    tid_t           head  [NPRIO];
    logic [TID_W:0] count [NPRIO];
    logic           empty [NPRIO];
    logic           pop   [NPRIO];
    logic           push_rq [NPRIO];
    logic           push_sp [NPRIO];
    cyc_t           hi_tag, lo_tag;
    logic           hi_due, lo_due;
    prio_e          rq_prio;
    logic           requeue;
    pick_t          grant;
    pick_t          issue;
    logic [SLOTS-1:0] free_mask;

    // Issue selection: high head if due, else low head if due.
    assign hi_due = !empty[PRIO_HI] && tag_due(cycle_i, hi_tag);
    assign lo_due = !empty[PRIO_LO] && tag_due(cycle_i, lo_tag);

    always_comb begin
        issue = '0;
        if (hi_due) begin
            issue = '{valid: 1'b1, tid: head[PRIO_HI], prio: PRIO_HI};
        end else if (lo_due) begin
            issue = '{valid: 1'b1, tid: head[PRIO_LO], prio: PRIO_LO};
        end
    end

    assign requeue = fb_valid_i && !fb_term_i;

    for (genvar p = 0; p < NPRIO; p++) begin : g_prio
        assign pop[p]     = issue.valid && (issue.prio == prio_e'(p));
        assign push_rq[p] = requeue && (rq_prio == prio_e'(p));
        assign push_sp[p] = grant.valid && (grant.prio == prio_e'(p));

        sched_runq #(
            .DEPTH  (SLOTS),
            .W      (TID_W),
            .PRELOAD(p == PRIO_LO)
        ) u_runq (
            .clk          (clk),
            .rst          (rst),
            .push_a_i     (push_rq[p]),
            .push_a_data_i(fb_tid_i),
            .push_b_i     (push_sp[p]),
            .push_b_data_i(grant.tid),
            .pop_i        (pop[p]),
            .head_o       (head[p]),
            .count_o      (count[p]),
            .empty_o      (empty[p])
        );
    end

    sched_tag_table u_tags (
        .clk        (clk),
        .rst        (rst),
        .cycle_i    (cycle_i),
        .rq_we_i    (requeue),
        .rq_tid_i   (fb_tid_i),
        .rq_tag_i   (delay_tag(cycle_i, fb_delay_i)),
        .sp_we_i    (grant.valid),
        .sp_tid_i   (grant.tid),
        .sp_tag_i   (cycle_i + cyc_t'(1)),
        .sp_prio_i  (grant.prio),
        .rd_a_tid_i (head[PRIO_HI]),
        .rd_a_tag_o (hi_tag),
        .rd_b_tid_i (head[PRIO_LO]),
        .rd_b_tag_o (lo_tag),
        .rd_c_tid_i (fb_tid_i),
        .rd_c_prio_o(rq_prio)
    );

    sched_slot_pool u_pool (
        .clk          (clk),
        .rst          (rst),
        .irq_i        (irq_i),
        .fork_i       (fb_valid_i && fb_fork_i),
        .fork_prio_i  (fb_fork_hi_i ? PRIO_HI : PRIO_LO),
        .release_i    (fb_valid_i && fb_term_i),
        .release_tid_i(fb_tid_i),
        .grant_valid_o(grant.valid),
        .grant_tid_o  (grant.tid),
        .grant_prio_o (grant.prio),
        .defer_o      (spawn_defer_o),
        .fault_o      (spawn_fault_o),
        .free_mask_o  (free_mask)
    );

    assign issue_valid_o = issue.valid;
    assign issue_tid_o   = issue.tid;
    assign issue_hi_o    = (issue.prio == PRIO_HI);
    assign spawn_valid_o = grant.valid;
    assign spawn_tid_o   = grant.tid;
    assign spawn_hi_o    = (grant.prio == PRIO_HI);

    AST_ISSUE_SLOT_LIVE: assert property (@(posedge clk) disable iff (rst)
        issue_valid_o |-> !free_mask[issue_tid_o]); // R7
    AST_SLOT_CONSERVE: assert property (@(posedge clk) disable iff (rst)
        ($countones(free_mask) + int'(count[PRIO_HI]) + int'(count[PRIO_LO])) <= int'(SLOTS)); // R8

endmodule

// File: tb/thread_issue_sched_tb.sv
`timescale 1ns/1ps
module thread_issue_sched_tb_top;
    import sched_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    logic       rst = 1'b1;
    cyc_t       cycle_i = 16'hFFE8;
    logic       fb_valid = 1'b0, fb_term = 1'b0, fb_fork = 1'b0, fb_fork_hi = 1'b0, irq = 1'b0;
    tid_t       fb_tid = '0;
    dly_t       fb_dly = '0;
    logic       issue_valid, issue_hi, spawn_valid, spawn_hi, spawn_defer, spawn_fault;
    tid_t       issue_tid, spawn_tid;

    thread_issue_sched dut_i (
        .clk(clk), .rst(rst), .cycle_i(cycle_i),
        .fb_valid_i(fb_valid), .fb_tid_i(fb_tid), .fb_delay_i(fb_dly),
        .fb_term_i(fb_term), .fb_fork_i(fb_fork), .fb_fork_hi_i(fb_fork_hi),
        .irq_i(irq),
        .issue_valid_o(issue_valid), .issue_tid_o(issue_tid), .issue_hi_o(issue_hi),
        .spawn_valid_o(spawn_valid), .spawn_tid_o(spawn_tid), .spawn_hi_o(spawn_hi),
        .spawn_defer_o(spawn_defer), .spawn_fault_o(spawn_fault)
    );

    int    checks = 0, errors = 0;
    bit    done = 0;
    string cur_req = "R1";
    int    dmap [8];

    // Reference model state
    tid_t  mq_hi [$];
    tid_t  mq_lo [$];
    cyc_t  mtag  [8];
    logic  mprio [8];
    logic [7:0] mfree;
    logic  mpend_v, mpend_hi;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic due(input cyc_t now, input cyc_t tag);
        cyc_t diff;
        diff = now - tag;
        return diff < 16'h8000;
    endfunction

    // d < 0 selects the per-thread delay map; term_sel 8 = any, -1 = none.
    task automatic step(input int d, input int term_sel, input bit fork_in,
                        input bit fork_hi_in, input bit irq_in);
        logic ev, ehi, sv, shi, sdef, sflt, np_v, np_hi, term_now, anyfree;
        tid_t et, st;
        int   dd, g;
        logic rv [3];
        logic rh [3];
        string lbl;
        @(negedge clk);
        lbl = (cycle_i >= 16'hFFFC || cycle_i < 16'h0004) ? "R5" : cur_req;
        ev = 0; ehi = 0; et = '0;
        if (mq_hi.size() > 0 && due(cycle_i, mtag[mq_hi[0]])) begin
            ev = 1; ehi = 1; et = mq_hi[0];
        end else if (mq_lo.size() > 0 && due(cycle_i, mtag[mq_lo[0]])) begin
            ev = 1; ehi = 0; et = mq_lo[0];
        end
        chk(lbl, "issue_valid", int'(issue_valid), int'(ev));
        if (ev) begin
            chk(lbl, "issue_tid", int'(issue_tid), int'(et));
            chk(lbl, "issue_hi", int'(issue_hi), int'(ehi));
        end
        dd = (d < 0) ? dmap[et] : d;
        term_now = ev && (term_sel == 8 || term_sel == int'(et));
        fb_valid = ev; fb_tid = et; fb_dly = dly_t'(dd);
        fb_term = term_now; fb_fork = ev && fork_in; fb_fork_hi = fork_hi_in; irq = irq_in;
        #1;
        rv[0] = mpend_v;       rh[0] = mpend_hi;
        rv[1] = irq_in;        rh[1] = 1'b1;
        rv[2] = ev && fork_in; rh[2] = fork_hi_in;
        anyfree = (mfree != 8'h00);
        st = '0;
        for (int i = 7; i >= 0; i--) if (mfree[i]) st = tid_t'(i);
        g = -1;
        for (int i = 0; i < 3; i++) if (rv[i] && g < 0) g = i;
        if (!anyfree) g = -1;
        sv = (g >= 0); shi = sv ? rh[g] : 1'b0;
        np_v = 0; np_hi = 0; sdef = 0; sflt = 0;
        for (int i = 0; i < 3; i++) begin
            if (rv[i] && i != g) begin
                if (!np_v) begin np_v = 1; np_hi = rh[i]; sdef = (i != 0); end
                else sflt = 1;
            end
        end
        chk(lbl, "spawn_valid", int'(spawn_valid), int'(sv));
        if (sv) begin
            chk(lbl, "spawn_tid", int'(spawn_tid), int'(st));
            chk(lbl, "spawn_hi", int'(spawn_hi), int'(shi));
        end
        chk(lbl, "spawn_defer", int'(spawn_defer), int'(sdef));
        chk(lbl, "spawn_fault", int'(spawn_fault), int'(sflt));
        // model update: pop, requeue, spawn, release
        if (ev) begin
            if (ehi) void'(mq_hi.pop_front()); else void'(mq_lo.pop_front());
        end
        if (ev && !term_now) begin
            mtag[et] = cycle_i + cyc_t'(dd) + 16'd1;
            if (mprio[et]) mq_hi.push_back(et); else mq_lo.push_back(et);
        end
        if (sv) begin
            mfree[st] = 1'b0; mtag[st] = cycle_i + 16'd1; mprio[st] = shi;
            if (shi) mq_hi.push_back(st); else mq_lo.push_back(st);
        end
        if (term_now) mfree[et] = 1'b1;
        mpend_v = np_v; mpend_hi = np_hi;
        @(posedge clk);
        #1;
        cycle_i = cycle_i + 16'd1;
        fb_valid = 0; fb_term = 0; fb_fork = 0; fb_fork_hi = 0; irq = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin dmap[i] = 0; mprio[i] = 0; mtag[i] = '0; end
        mfree = 8'hFE; mpend_v = 0; mpend_hi = 0;
        mq_lo.push_back(3'd0);
        repeat (3) begin @(posedge clk); #1; cycle_i = cycle_i + 16'd1; end
        mtag[0] = cycle_i - 16'd1;  // value seen on the last reset edge
        rst = 1'b0;

        cur_req = "R1";  // R1: slot 0 issues alone right after reset
        step(0, -1, 0, 0, 0);

        cur_req = "R4";  // R4: delay codes 0..3, crossing the wrap (R5)
        for (int k = 0; k < 32; k++) step(k % 4, -1, 0, 0, 0);

        cur_req = "R8";  // R8: low-priority forks take slots 1, 2, 3
        for (int k = 0; k < 3; k++) step(0, -1, 1, 0, 0);

        cur_req = "R3";  // R3: round-robin across four low threads
        for (int k = 0; k < 12; k++) step(0, -1, 0, 0, 0);

        cur_req = "R2";  // R2: interrupt task preempts the low queue
        step(0, -1, 0, 0, 1);
        for (int k = 0; k < 6; k++) step(0, -1, 0, 0, 0);
        for (int k = 0; k < 8; k++) step(3, -1, 0, 0, 0);

        cur_req = "R7";  // R7: terminate slots 4 and 2, then reuse slot 2
        for (int k = 0; k < 8; k++) step(0, 4, 0, 0, 0);
        for (int k = 0; k < 8; k++) step(0, 2, 0, 0, 0);
        step(0, -1, 1, 0, 0);

        cur_req = "R9";  // R9: interrupt beats fork, fork served next cycle
        step(0, -1, 1, 0, 1);
        step(0, -1, 0, 0, 0);

        cur_req = "R10"; // R10: fill the pool, then defer and fault
        step(0, -1, 1, 0, 0);
        step(0, -1, 1, 0, 0);
        step(0, -1, 1, 1, 0);
        step(0, -1, 1, 0, 0);
        step(0, -1, 1, 0, 1);

        cur_req = "R11"; // R11: held-back request wins a freed slot over a fork
        step(0, 8, 0, 0, 0);
        step(0, -1, 1, 0, 0);
        step(0, 8, 0, 0, 0);
        step(0, -1, 0, 0, 0);

        cur_req = "R6";  // R6: idle when empty and head-of-line blocking
        for (int k = 0; k < 24; k++) step(0, 8, 0, 0, 0);
        for (int k = 0; k < 3; k++) step(0, -1, 0, 0, 0);
        step(0, -1, 0, 0, 1);
        step(0, 0, 1, 0, 0);
        dmap[1] = 3; dmap[0] = 0;
        step(-1, -1, 1, 0, 0);
        for (int k = 0; k < 10; k++) step(-1, -1, 0, 0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL %s watchdog actual=hung expected=finished", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule